// File: doc/BRIEF.md
# Wakeup interrupt polarity normalizer

A bank of per-pin interrupt conditioners placed ahead of an interrupt controller that can only take active-high levels or rising edges. Every pin carries a 3-bit sense code and a mask bit. The block turns active-low levels, falling edges and dual edges into the single form the controller accepts. Each result is registered and presented on the matching bit of `irq_o`.

Software programs the bank through a word-wide register port. Writes are a single-cycle strobe and reads are combinational on the address. Enable bits are packed one bit per pin, 32 to a word, starting at byte 0x10. Each pin also has its own configuration word starting at byte 0x110. Edge modes compare the pin with a registered copy of its value one cycle earlier. A qualifying edge yields a pulse one clock wide. Pin inputs are assumed to be synchronous to `clk_i` already.

Top module: `wake_polarity_norm`

## Requirements
- R1: After reset every `irq_o` bit is 0, and every enable word and configuration word reads 0.
- R2: Enable bit of pin n sits at byte address 0x10 + 4*(n/32), bit n%32, and reads back as last written; bits for pins at or above NUM_PINS (126) read 0 (word 0x1C reads 0x3FFFFFFF after writing all ones).
- R3: Pin n's sense code is held in bits [2:0] of byte address 0x110 + 4*n; upper bits read 0.
- R4: Sense 3'b000 (level, active low): `irq_o[n]` equals the inverted pin, one clock after the pin is sampled.
- R5: Sense 3'b100 (level, active high): `irq_o[n]` follows the pin, one clock late.
- R6: Sense 3'b110 (rising): a low-to-high pin change gives a single-cycle high pulse on `irq_o[n]`, and a falling change or steady pin gives nothing.
- R7: Sense 3'b010 (falling): a high-to-low change gives a single-cycle pulse, and a rising change gives nothing.
- R8: Sense 3'b111 (dual): either change gives a single-cycle pulse.
- R9: Any other sense code (001, 011, 101) keeps `irq_o[n]` at 0.
- R10: With its enable bit clear, a pin's output is 0 from the clock after the clear, whatever its mode and pin.
- R11: Writes to unaligned addresses, to addresses outside both windows, or to configuration slots at or above NUM_PINS change no state, and such addresses read 0.
- R12: Rewriting a pin's sense code while the pin holds steady produces no edge pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe, one word per cycle |
| bus_addr_i | input | 12 | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| pin_i | input | 126 | Interrupt pins, synchronous to `clk_i` |
| irq_o | output | 126 | Normalized, masked interrupts to the parent controller |

## Verification
Each sense code is driven with four kinds of pin pattern: a rise, a fall, a steady high and a steady low. Each result is checked in the cycle after the change and again one cycle later. This separates the level modes, which hold the output, from the edge modes, which pulse once. It also tells the rising, falling and dual modes apart by which transition fires them. The reserved codes and the masked case use the same patterns and must stay silent. Register tests cover the padded top enable word, the highest pin slot and stray addresses. A steady pin across several sense rewrites shows that a mode change alone never fires.

// File: rtl/wpn_pkg.sv
package wpn_pkg;

  localparam int SENSE_W = 3;

  localparam logic [SENSE_W-1:0] SNS_LVL_LOW   = 3'b000;
  localparam logic [SENSE_W-1:0] SNS_EDGE_FALL = 3'b010;
  localparam logic [SENSE_W-1:0] SNS_LVL_HIGH  = 3'b100;
  localparam logic [SENSE_W-1:0] SNS_EDGE_RISE = 3'b110;
  localparam logic [SENSE_W-1:0] SNS_EDGE_BOTH = 3'b111;

  // True for the five defined codes.
  function automatic logic sense_known(input logic [SENSE_W-1:0] code);
    return (code == SNS_LVL_LOW)   || (code == SNS_LVL_HIGH) ||
           (code == SNS_EDGE_RISE) || (code == SNS_EDGE_FALL) ||
           (code == SNS_EDGE_BOTH);
  endfunction

  // Normalized detection from the current pin and its previous sample.
  function automatic logic sense_eval(input logic [SENSE_W-1:0] code,
                                      input logic cur, input logic prev);
    logic r;
    case (code)
      SNS_LVL_LOW:   r = ~cur;
      SNS_LVL_HIGH:  r = cur;
      SNS_EDGE_RISE: r = cur & ~prev;
      SNS_EDGE_FALL: r = ~cur & prev;
      SNS_EDGE_BOTH: r = cur ^ prev;
      default:       r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wpn_pin_cond.sv
module wpn_pin_cond
  import wpn_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pin_i,
  input  logic [SENSE_W-1:0] sense_i,
  input  logic               enable_i,
  output logic               irq_o
);

  logic prev_q;
  logic irq_q;
  logic hit;   // raw detection before masking

  assign hit = sense_eval(sense_i, pin_i, prev_q);

  // History always tracks the pin, so a new sense code sees a fresh sample.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= pin_i;
      irq_q  <= enable_i & hit;
    end
  end

  assign irq_o = irq_q;

  // R10
  mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !irq_q);

  // R9
  unknown_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sense_known(sense_i) |=> !irq_q);

  // R5
  level_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && sense_i == SNS_LVL_HIGH) |=> (irq_q == $past(pin_i)));

  // R4
  level_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && sense_i == SNS_LVL_LOW) |=> (irq_q == !$past(pin_i)));

  // R6
  rise_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && sense_i == SNS_EDGE_RISE && $past(sense_i) == SNS_EDGE_RISE)
      |=> !irq_q);

  // R7
  fall_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && sense_i == SNS_EDGE_FALL && $past(sense_i) == SNS_EDGE_FALL)
      |=> !irq_q);

endmodule

// File: rtl/wpn_regfile.sv
module wpn_regfile
  import wpn_pkg::*;
#(
  parameter int NUM_PINS = 126,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int EN_BASE  = 'h10,
  parameter int CFG_BASE = 'h110
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [NUM_PINS-1:0]         en_o,
  output logic [NUM_PINS*SENSE_W-1:0] sense_o
);

  localparam int EN_WORDS = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int PAD_BITS = EN_WORDS * DATA_W;
  localparam int WIDX_W   = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1;
  localparam int PIDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [PAD_BITS-1:0] IMPL_MASK =
    (PAD_BITS'(1) << NUM_PINS) - PAD_BITS'(1);

  // Word-aligned address inside [base, base + 4*slots)
  function automatic logic win_hit(input logic [ADDR_W-1:0] a,
                                   input int base, input int slots);
    int ai;
    ai = int'(a);
    return (a[1:0] == 2'b00) && (ai >= base) && (ai < base + 4 * slots);
  endfunction

  function automatic int slot_of(input logic [ADDR_W-1:0] a, input int base);
    return (int'(a) - base) / 4;
  endfunction

  logic              en_hit;
  logic              cfg_hit;
  logic [WIDX_W-1:0] en_idx;
  logic [PIDX_W-1:0] cfg_idx;

  assign en_hit  = win_hit(addr_i, EN_BASE, EN_WORDS);
  assign cfg_hit = win_hit(addr_i, CFG_BASE, NUM_PINS);
  assign en_idx  = WIDX_W'(slot_of(addr_i, EN_BASE));
  assign cfg_idx = PIDX_W'(slot_of(addr_i, CFG_BASE));

  logic [PAD_BITS-1:0]                en_q;
  logic [NUM_PINS-1:0][SENSE_W-1:0]   cfg_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (wr_i && en_hit) begin
      for (int w = 0; w < EN_WORDS; w++) begin
        if (en_idx == WIDX_W'(w))
          en_q[w*DATA_W +: DATA_W] <= wdata_i & IMPL_MASK[w*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_i && cfg_hit) begin
      cfg_q[cfg_idx] <= wdata_i[SENSE_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (en_hit)
      rdata_o = en_q[en_idx*DATA_W +: DATA_W];
    else if (cfg_hit)
      rdata_o = DATA_W'(cfg_q[cfg_idx]);
  end

  assign en_o    = en_q[NUM_PINS-1:0];
  assign sense_o = cfg_q;

  // R11
  stray_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !en_hit && !cfg_hit) |=> ($stable(en_q) && $stable(cfg_q)));

  // R2
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_hit && en_idx == WIDX_W'(EN_WORDS - 1)) |->
      ((rdata_o & ~IMPL_MASK[(EN_WORDS-1)*DATA_W +: DATA_W]) == '0));

endmodule

// File: rtl/wake_polarity_norm.sv
module wake_polarity_norm
  import wpn_pkg::*;
#(
  parameter int NUM_PINS = 126,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int EN_BASE  = 'h10,
  parameter int CFG_BASE = 'h110
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_wr_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] irq_o
);

  logic [NUM_PINS-1:0]         pin_en;
  logic [NUM_PINS*SENSE_W-1:0] pin_sense;

  wpn_regfile #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .EN_BASE  (EN_BASE),
    .CFG_BASE (CFG_BASE)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .en_o    (pin_en),
    .sense_o (pin_sense)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    wpn_pin_cond u_cond (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (pin_i[n]),
      .sense_i  (pin_sense[n*SENSE_W +: SENSE_W]),
      .enable_i (pin_en[n]),
      .irq_o    (irq_o[n])
    );
  end

endmodule

// File: tb/test_wake_polarity_norm.sv
module test_wake_polarity_norm;

  localparam int NP = 126;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0;
  logic [11:0]    bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NP-1:0]  pin = '0;
  logic [NP-1:0]  irq;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  wake_polarity_norm i_wake_polarity_norm (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .pin_i       (pin),
    .irq_o       (irq)
  );

  // vector: {sense[2:0], enable, prev pin, new pin, expected right after change}
  localparam int NV = 18;
  localparam logic [6:0] VEC [NV] = '{
    {3'b000, 1'b1, 1'b1, 1'b0, 1'b1},  // R4
    {3'b000, 1'b1, 1'b0, 1'b1, 1'b0},  // R4
    {3'b100, 1'b1, 1'b0, 1'b1, 1'b1},  // R5
    {3'b100, 1'b1, 1'b1, 1'b0, 1'b0},  // R5
    {3'b110, 1'b1, 1'b0, 1'b1, 1'b1},  // R6
    {3'b110, 1'b1, 1'b1, 1'b0, 1'b0},  // R6
    {3'b110, 1'b1, 1'b1, 1'b1, 1'b0},  // R6
    {3'b010, 1'b1, 1'b1, 1'b0, 1'b1},  // R7
    {3'b010, 1'b1, 1'b0, 1'b1, 1'b0},  // R7
    {3'b010, 1'b1, 1'b0, 1'b0, 1'b0},  // R7
    {3'b111, 1'b1, 1'b0, 1'b1, 1'b1},  // R8
    {3'b111, 1'b1, 1'b1, 1'b0, 1'b1},  // R8
    {3'b111, 1'b1, 1'b1, 1'b1, 1'b0},  // R8
    {3'b001, 1'b1, 1'b0, 1'b1, 1'b0},  // R9
    {3'b011, 1'b1, 1'b1, 1'b0, 1'b0},  // R9
    {3'b101, 1'b1, 1'b0, 1'b1, 1'b0},  // R9
    {3'b110, 1'b0, 1'b0, 1'b1, 1'b0},  // R10
    {3'b000, 1'b0, 1'b0, 1'b0, 1'b0}   // R10
  };

  function automatic string vec_req(input logic [2:0] s, input logic e);
    if (!e) return "R10";
    case (s)
      3'b000: return "R4";
      3'b100: return "R5";
      3'b110: return "R6";
      3'b010: return "R7";
      3'b111: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [11:0] cfg_addr(input int p);
    return 12'(32'h110 + 4 * p);
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", 32'(irq[31:0]), 32'h0);
    chk("R1", 32'(irq[NP-1:96]), 32'h0);
    rd(12'h010, d); chk("R1", d, 32'h0);
    rd(12'h01C, d); chk("R1", d, 32'h0);
    rd(cfg_addr(0), d); chk("R1", d, 32'h0);
    rd(cfg_addr(NP-1), d); chk("R1", d, 32'h0);

    // R2 enable bank readback and padding
    wr(12'h01C, 32'hFFFF_FFFF);
    rd(12'h01C, d); chk("R2", d, 32'h3FFF_FFFF);
    wr(12'h01C, 32'h0);
    wr(12'h014, 32'hA5A5_1234);
    rd(12'h014, d); chk("R2", d, 32'hA5A5_1234);
    rd(12'h010, d); chk("R2", d, 32'h0);
    wr(12'h014, 32'h0);

    // R3 configuration word, low three bits only
    wr(cfg_addr(NP-1), 32'hFFFF_FFFE);
    rd(cfg_addr(NP-1), d); chk("R3", d, 32'h6);
    wr(cfg_addr(7), 32'h0000_0005);
    rd(cfg_addr(7), d); chk("R3", d, 32'h5);

    // R11 stray writes
    wr(cfg_addr(NP), 32'h7);
    rd(cfg_addr(NP), d); chk("R11", d, 32'h0);
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h020, d); chk("R11", d, 32'h0);
    wr(12'h111, 32'h6);
    rd(12'h110, d); chk("R11", d, 32'h0);
    rd(cfg_addr(NP-1), d); chk("R11", d, 32'h6);
    rd(12'h010, d); chk("R11", d, 32'h0);

    // Table walk on pin 5
    for (int v = 0; v < NV; v++) begin
      logic [2:0] s;
      logic e, p0, p1, x0, x1;
      {s, e, p0, p1, x0} = VEC[v];
      x1 = (s == 3'b000 || s == 3'b100) ? x0 : 1'b0;
      wr(cfg_addr(5), 32'(s));
      wr(12'h010, e ? 32'h20 : 32'h0);
      pin[5] = p0;
      repeat (3) @(negedge clk);
      pin[5] = p1;
      @(negedge clk);
      chk(vec_req(s, e), 32'(irq[5]), 32'(x0));
      @(negedge clk);
      chk(vec_req(s, e), 32'(irq[5]), 32'(x1));
      chk("R10", 32'(irq[31:0] & ~32'h20), 32'h0);
    end
    pin[5] = 1'b0;
    wr(12'h010, 32'h0);

    // R10 mask on pin 40, word 1 bit 8
    wr(cfg_addr(40), 32'h4);
    pin[40] = 1'b1;
    wr(12'h014, 32'h100);
    @(negedge clk);
    chk("R10", 32'(irq[40]), 32'h1);
    wr(12'h014, 32'h0);
    @(negedge clk);
    chk("R10", 32'(irq[40]), 32'h0);
    pin[40] = 1'b0;

    // R12 sense rewrites with a steady high pin
    pin[5] = 1'b1;
    wr(cfg_addr(5), 32'h0);
    wr(12'h010, 32'h20);
    repeat (2) @(negedge clk);
    chk("R12", 32'(irq[5]), 32'h0);
    wr(cfg_addr(5), 32'h6);
    chk("R12", 32'(irq[5]), 32'h0);
    @(negedge clk);
    chk("R12", 32'(irq[5]), 32'h0);
    wr(cfg_addr(5), 32'h7);
    chk("R12", 32'(irq[5]), 32'h0);
    @(negedge clk);
    chk("R12", 32'(irq[5]), 32'h0);
    wr(cfg_addr(5), 32'h2);
    @(negedge clk);
    chk("R12", 32'(irq[5]), 32'h0);

    // R8 dual edge on the highest pin (word 3 bit 29)
    wr(cfg_addr(NP-1), 32'h7);
    wr(12'h01C, 32'h2000_0000);
    repeat (2) @(negedge clk);
    chk("R8", 32'(irq[NP-1]), 32'h0);
    pin[NP-1] = 1'b1;
    @(negedge clk); chk("R8", 32'(irq[NP-1]), 32'h1);
    @(negedge clk); chk("R8", 32'(irq[NP-1]), 32'h0);
    pin[NP-1] = 1'b0;
    @(negedge clk); chk("R8", 32'(irq[NP-1]), 32'h1);
    @(negedge clk); chk("R8", 32'(irq[NP-1]), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule